// File: doc/BRIEF.md
# Serial Converter Output Framing Controller

This block is the digital side of a two-input serial successive-approximation converter. It watches an active-low select line and a serial clock from the host, both sampled on the chip's system clock. From the level of the serial clock at the moment select falls, it picks one of two timing modes. In the first mode the host clock paces the conversion. In the second, an on-chip oscillator paces it and the host only reads the result. The block then emits a fixed-length frame on a serial data pin. While select is high the block sits in a power-down state and the pin is not driven.

The analog sampling path is outside the block. It receives a conversion-start pulse and the channel to use, and it returns a 12-bit result: 10 data bits followed by 2 extra resolution bits. In the host-clocked mode the result arrives with a valid strobe. In the oscillator mode the block counts oscillator ticks, takes the result at the last tick and then raises its end-of-conversion flag. The block alternates between the two input channels from one conversion to the next. A build option fixes it to a single channel.

Top module: `sar_serial_framer`

## Requirements
- R1: While reset is asserted, `pwrDown` is 1 and `doutEn`, `dout` and `convStart` are 0.
- R2: A cycle in which `csN` falls while `sclk` is 0 selects the host-clocked mode. From the next cycle `doutEn` is 1, `pwrDown` is 0, and `dout` shows frame position 0, which is a 1.
- R3: A `csN` fall while `sclk` is 1 selects the oscillator mode. `dout` stays 0 while the block waits for the first `sclk` fall, and then for CONV_TICKS `oscTick` pulses after it. In that time further `sclk` falls have no effect. The cycle after the final tick, `dout` shows 1.
- R4: The frame is 16 positions long. Positions 0 to 2 carry 1, position 3 carries the channel bit, positions 4 to 13 carry result[11:2] with the most significant bit first, and positions 14 and 15 carry result[1:0]. The position advances by exactly one for each detected `sclk` fall, and the new bit appears in the cycle after the edge that saw the fall.
- R5: At positions 16 and later, which are reached by further falls with `csN` held low, `dout` is 0.
- R6: In any cycle with `csN` high, `doutEn` is 0 and `pwrDown` is 1 from the next cycle on. This also aborts a conversion in progress, and `dout` is then 0.
- R7: The first frame after reset carries channel bit 0 (channel 0). Each later `csN` fall uses the other channel, and a frame that was aborted still counts as a use.
- R8: `convStart` is a pulse one cycle wide. In the host-clocked mode it follows the second `sclk` fall of a frame; in the oscillator mode it follows the first.
- R9: In the host-clocked mode the result register loads `resultData` on `resultValid`. In the oscillator mode it loads `resultData` at the final tick, and `resultValid` is ignored.
- R10: With SINGLE_CHAN=1 the channel bit is always 1 and no alternation takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low select; high means power-down |
| sclk | input | 1 | Host serial clock, sampled on clk |
| oscTick | input | 1 | One-cycle tick from the internal conversion oscillator |
| resultValid | input | 1 | Result strobe from the converter core (host-clocked mode) |
| resultData | input | DATA_BITS+SUB_BITS | Conversion result, data bits above the extra bits |
| dout | output | 1 | Serial data, 0 when not enabled |
| doutEn | output | 1 | Output-driver enable; the pad is high impedance when 0 |
| pwrDown | output | 1 | Power-down state flag |
| convStart | output | 1 | Sampling and conversion start pulse |
| convChan | output | 1 | Channel bit of the current frame |

## Verification
The bench builds two copies side by side on shared inputs. One uses the defaults: two channels and a 12-tick oscillator wait. The other is built with SINGLE_CHAN=1 and CONV_TICKS=3. Because the second copy finishes its oscillator conversion well before the first, the same stimulus drives it through host clock falls in the read phase while the first copy must still ignore them. The single-channel copy also shows the fixed channel bit across the frames in which the first copy alternates, including the frame after an abort.

// File: rtl/sar_framer_pkg.sv
package sar_framer_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_EXT,
    ST_INT_ARM,
    ST_INT_CONV,
    ST_INT_READ
  } framer_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startFrame;
    logic advance;
    logic loadResult;
    logic holdEoc;
  } framer_strobe_t;

endpackage

// File: rtl/sar_framer_ctrl.sv
module sar_framer_ctrl
  import sar_framer_pkg::*;
#(
  parameter int CONV_TICKS = 12
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           csN,
  input  logic           sclk,
  input  logic           oscTick,
  input  logic           resultValid,
  output framer_strobe_t strobe,
  output logic           active,
  output logic           pwrDown,
  output logic           convStart
);

  localparam int TICK_W = (CONV_TICKS > 1) ? $clog2(CONV_TICKS) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(CONV_TICKS - 1);

  framer_state_t     st, stNext;
  logic [TICK_W-1:0] tickCnt, tickNext;
  logic [1:0]        extFalls, extFallsNext;
  logic              csPrev, sclkPrev, startQ, startNext;
  logic              csFall, sclkFall;

  assign csFall   = csPrev & ~csN;
  assign sclkFall = sclkPrev & ~sclk;

  always_comb begin
    stNext         = st;
    tickNext       = tickCnt;
    extFallsNext   = extFalls;
    startNext      = 1'b0;
    strobe         = '0;
    strobe.holdEoc = (st == ST_INT_ARM) || (st == ST_INT_CONV);
    if (csN) begin
      stNext = ST_OFF;
    end else if (csFall) begin
      strobe.startFrame = 1'b1;
      stNext            = sclk ? ST_INT_ARM : ST_EXT;
      tickNext          = '0;
      extFallsNext      = '0;
    end else begin
      case (st)
        ST_EXT: begin
          strobe.advance    = sclkFall;
          strobe.loadResult = resultValid;
          if (sclkFall && extFalls != 2'd2) begin
            extFallsNext = extFalls + 2'd1;
            startNext    = (extFalls == 2'd1);
          end
        end
        ST_INT_ARM: begin
          if (sclkFall) begin
            stNext    = ST_INT_CONV;
            startNext = 1'b1;
            tickNext  = '0;
          end
        end
        ST_INT_CONV: begin
          if (oscTick) begin
            if (tickCnt == TICK_LAST) begin
              strobe.loadResult = 1'b1;
              stNext            = ST_INT_READ;
            end else begin
              tickNext = tickCnt + 1'b1;
            end
          end
        end
        ST_INT_READ: strobe.advance = sclkFall;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_OFF;
      tickCnt  <= '0;
      extFalls <= '0;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
      startQ   <= 1'b0;
    end else begin
      st       <= stNext;
      tickCnt  <= tickNext;
      extFalls <= extFallsNext;
      csPrev   <= csN;
      sclkPrev <= sclk;
      startQ   <= startNext;
    end
  end

  assign active    = (st != ST_OFF);
  assign pwrDown   = (st == ST_OFF);
  assign convStart = startQ;

  // R6: select high always lands in power-down
  assert_cs_high_sleeps_R6: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> pwrDown);

  // R8: start pulse never stretches
  assert_start_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R3: read phase is entered only on an oscillator tick
  assert_eoc_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_INT_READ && $past(st) == ST_INT_CONV) |-> $past(oscTick));

endmodule

// File: rtl/sar_framer_datapath.sv
module sar_framer_datapath
  import sar_framer_pkg::*;
#(
  parameter int DATA_BITS   = 10,
  parameter int SUB_BITS    = 2,
  parameter int HEAD_ONES   = 3,
  parameter bit SINGLE_CHAN = 1'b0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  framer_strobe_t                strobe,
  input  logic                          active,
  input  logic [DATA_BITS+SUB_BITS-1:0] resultData,
  output logic                          doutBit,
  output logic                          chanId
);

  localparam int RES_W     = DATA_BITS + SUB_BITS;
  localparam int FRAME_LEN = HEAD_ONES + 1 + RES_W;
  localparam int POS_W     = $clog2(FRAME_LEN + 1);

  logic [POS_W-1:0] posCnt;
  logic [RES_W-1:0] resultReg, shifted;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posCnt    <= '0;
      resultReg <= '0;
    end else begin
      if (strobe.startFrame) posCnt <= '0;
      else if (strobe.advance && posCnt != POS_W'(FRAME_LEN)) posCnt <= posCnt + 1'b1;
      if (strobe.loadResult) resultReg <= resultData;
    end
  end

  generate
    if (SINGLE_CHAN) begin : g_single
      assign chanId = 1'b1;
    end else begin : g_dual
      logic nextChan, chidReg;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          nextChan <= 1'b0;
          chidReg  <= 1'b0;
        end else if (strobe.startFrame) begin
          chidReg  <= nextChan;
          nextChan <= ~nextChan;
        end
      end
      assign chanId = chidReg;

      // R7: the channel queued next always differs from the one in use
      assert_alternate_R7: assert property (@(posedge clk) disable iff (!rstN)
        strobe.startFrame |=> (nextChan != chidReg));
    end
  endgenerate

  assign shifted = resultReg << (posCnt - POS_W'(HEAD_ONES + 1));

  always_comb begin
    if (!active || strobe.holdEoc)         doutBit = 1'b0;
    else if (posCnt < POS_W'(HEAD_ONES))   doutBit = 1'b1;
    else if (posCnt == POS_W'(HEAD_ONES))  doutBit = chanId;
    else if (posCnt < POS_W'(FRAME_LEN))   doutBit = shifted[RES_W-1];
    else                                   doutBit = 1'b0;
  end

  // R5: past the frame end only zeros leave the block
  assert_tail_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (posCnt == POS_W'(FRAME_LEN)) |-> !doutBit);

endmodule

// File: rtl/sar_serial_framer.sv
module sar_serial_framer
  import sar_framer_pkg::*;
#(
  parameter int DATA_BITS   = 10,
  parameter int SUB_BITS    = 2,
  parameter int HEAD_ONES   = 3,
  parameter int CONV_TICKS  = 12,
  parameter bit SINGLE_CHAN = 1'b0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          csN,
  input  logic                          sclk,
  input  logic                          oscTick,
  input  logic                          resultValid,
  input  logic [DATA_BITS+SUB_BITS-1:0] resultData,
  output logic                          dout,
  output logic                          doutEn,
  output logic                          pwrDown,
  output logic                          convStart,
  output logic                          convChan
);

  framer_strobe_t strobe;
  logic           active;

  sar_framer_ctrl #(.CONV_TICKS(CONV_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .oscTick(oscTick),
    .resultValid(resultValid), .strobe(strobe), .active(active),
    .pwrDown(pwrDown), .convStart(convStart)
  );

  sar_framer_datapath #(
    .DATA_BITS(DATA_BITS), .SUB_BITS(SUB_BITS),
    .HEAD_ONES(HEAD_ONES), .SINGLE_CHAN(SINGLE_CHAN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .active(active),
    .resultData(resultData), .doutBit(dout), .chanId(convChan)
  );

  assign doutEn = active;

endmodule

// File: tb/sim_sar_serial_framer.sv
module sim_sar_serial_framer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, oscTick = 1'b0, resultValid = 1'b0;
  logic [11:0] resultData = '0;
  logic [1:0] doutV, enV, pdV, startV, chanV;
  int nChecks = 0, nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_serial_framer u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .oscTick(oscTick),
    .resultValid(resultValid), .resultData(resultData), .dout(doutV[0]),
    .doutEn(enV[0]), .pwrDown(pdV[0]), .convStart(startV[0]), .convChan(chanV[0]));

  sar_serial_framer #(.CONV_TICKS(3), .SINGLE_CHAN(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .oscTick(oscTick),
    .resultValid(resultValid), .resultData(resultData), .dout(doutV[1]),
    .doutEn(enV[1]), .pwrDown(pdV[1]), .convStart(startV[1]), .convChan(chanV[1]));

  // behavioural reference: mode 0 off, 1 host clocked, 2 armed, 3 converting, 4 reading
  int mMode[2], mPos[2], mTicks[2], mChid[2], mNext[2];
  logic [11:0] mRes[2];
  logic mStart[2];
  int lim[2] = '{12, 3};
  int single[2] = '{0, 1};
  logic prevCs, prevSclk, csF, sF;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin
        mMode[i] = 0; mPos[i] = 0; mTicks[i] = 0; mNext[i] = 0;
        mChid[i] = single[i]; mRes[i] = '0; mStart[i] = 1'b0;
      end
      prevCs = 1'b1; prevSclk = 1'b0;
    end else begin
      csF = prevCs && !csN;
      sF  = prevSclk && !sclk;
      for (int i = 0; i < 2; i++) begin
        mStart[i] = 1'b0;
        if (csN) mMode[i] = 0;
        else if (csF) begin
          mChid[i] = single[i] ? 1 : mNext[i];
          if (single[i] == 0) mNext[i] = 1 - mNext[i];
          mPos[i] = 0; mTicks[i] = 0;
          mMode[i] = sclk ? 2 : 1;
        end else begin
          case (mMode[i])
            1: begin
              if (sF) begin
                if (mPos[i] == 1) mStart[i] = 1'b1;
                if (mPos[i] < 16) mPos[i]++;
              end
              if (resultValid) mRes[i] = resultData;
            end
            2: if (sF) begin mMode[i] = 3; mTicks[i] = 0; mStart[i] = 1'b1; end
            3: if (oscTick) begin
              if (mTicks[i] == lim[i] - 1) begin mRes[i] = resultData; mMode[i] = 4; end
              else mTicks[i]++;
            end
            4: if (sF && mPos[i] < 16) mPos[i]++;
            default: ;
          endcase
        end
      end
      prevCs = csN; prevSclk = sclk;
    end
  end

  function automatic int expBit(int i);
    if (mMode[i] == 0 || mMode[i] == 2 || mMode[i] == 3) return 0;
    if (mPos[i] < 3) return 1;
    if (mPos[i] == 3) return mChid[i];
    if (mPos[i] < 16) return int'(mRes[i][15 - mPos[i]]);
    return 0;
  endfunction

  function automatic string tagFor(int i);
    if (mMode[i] == 0) return "R6";
    if (mMode[i] == 2 || mMode[i] == 3) return "R3";
    if (mPos[i] >= 16) return "R5";
    if (mPos[i] == 3) return single[i] ? "R10" : "R7";
    return "R4";
  endfunction

  task automatic chk(string req, int act, int exp, string what);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int i = 0; i < 2; i++) begin
        chk(tagFor(i), int'(doutV[i]), expBit(i), "dout vs model");
        chk("R2", int'(enV[i]), int'(mMode[i] != 0), "doutEn vs model");
        chk("R6", int'(pdV[i]), int'(mMode[i] == 0), "pwrDown vs model");
        chk("R8", int'(startV[i]), int'(mStart[i]), "convStart vs model");
      end
    end
  end

  task automatic fallOnce();
    @(posedge clk); #1 sclk = 1'b1;
    repeat (2) @(posedge clk);
    #1 sclk = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic tickOnce();
    @(posedge clk); #1 oscTick = 1'b1;
    @(posedge clk); #1 oscTick = 1'b0;
  endtask

  task automatic validPulse(input logic [11:0] d);
    @(posedge clk); #1 resultData = d; resultValid = 1'b1;
    @(posedge clk); #1 resultValid = 1'b0;
  endtask

  task automatic readFrame(input logic [17:0] vec, input bit giveValid,
                           input logic [11:0] d, input string dataTag);
    for (int p = 0; p < 18; p++) begin
      @(negedge clk);
      chk(p >= 16 ? "R5" : (p == 3 ? "R7" : (p >= 4 ? dataTag : "R4")),
          int'(doutV[0]), int'(vec[17 - p]), $sformatf("frame position %0d", p));
      if (giveValid && p == 2) validPulse(d);
      if (p < 17) fallOnce();
    end
  endtask

  task automatic deselect();
    @(posedge clk); #1 csN = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R6", int'(enV[0]), 0, "doutEn after deselect");
    chk("R6", int'(pdV[0]), 1, "pwrDown after deselect");
    repeat (2) @(posedge clk);
  endtask

  task automatic extFrame(input logic [11:0] d, input logic chid);
    @(posedge clk); #1 sclk = 1'b0; csN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R2", int'(enV[0]), 1, "doutEn host-clocked mode");
    readFrame({3'b111, chid, d, 2'b00}, 1'b1, d, "R4");
    deselect();
  endtask

  task automatic intFrame(input logic [11:0] d, input logic chid);
    @(posedge clk); #1 sclk = 1'b1;
    repeat (2) @(posedge clk);
    #1 csN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3", int'(doutV[0]), 0, "busy flag before first fall");
    @(posedge clk); #1 sclk = 1'b0;
    repeat (2) @(posedge clk);
    validPulse(~d);                       // R9: ignored in oscillator mode
    @(posedge clk); #1 resultData = d;
    for (int t = 0; t < 12; t++) begin
      tickOnce();
      if (t == 5) fallOnce();             // R3: fall during conversion ignored
      if (t == 10) begin
        @(negedge clk);
        chk("R3", int'(doutV[0]), 0, "busy flag before last tick");
      end
    end
    @(negedge clk);
    chk("R3", int'(doutV[0]), 1, "end-of-conversion flag");
    readFrame({3'b111, chid, d, 2'b00}, 1'b0, d, "R9");
    deselect();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk("R1", int'(doutV[i]), 0, "dout in reset");
      chk("R1", int'(enV[i]), 0, "doutEn in reset");
      chk("R1", int'(pdV[i]), 1, "pwrDown in reset");
      chk("R1", int'(startV[i]), 0, "convStart in reset");
    end
    @(posedge clk); #1 rstN = 1'b1;
    repeat (3) @(posedge clk);

    extFrame(12'hA5C, 1'b0);
    extFrame(12'h3F1, 1'b1);
    intFrame(12'h2B7, 1'b0);

    // abort: host-clocked frame dropped after one fall, channel 1 consumed
    @(posedge clk); #1 sclk = 1'b0; csN = 1'b0;
    repeat (2) @(posedge clk);
    fallOnce();
    deselect();

    extFrame(12'h0F0, 1'b0);              // R7: channel 0 again after abort

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule